// File: doc/BRIEF.md
# Secure Function Return Unit

This block sits beside the branch logic of a core that has an optional security extension. Each branch target is offered to it with a valid strobe and sorted into one of three classes: an ordinary branch, an exception return or a secure function return. The choice depends on two magic thresholds and on whether the security extension is built in. Ordinary branches and exception returns produce a one-cycle indication only. The full exception-return unstack is done elsewhere, so this block only raises a request for it. An exception-return target seen outside handler mode is dropped without any effect.

A secure function return starts a short unstack sequence. The block picks one of four secure stack pointers using the current mode and an alternate-stack select bit. It then reads two words through a secure memory port: the return address at the frame pointer and the saved status word at the frame pointer plus 4. The saved exception field is checked against the current exception number. On a pass, the block commits the new PC, the instruction-mode bit, the exception number, the floating-point-secure-active bit and the advanced stack pointer. On a fail, it raises an invalid-return usage fault. A bus error on either read stops the sequence with no commit.

Top module: `sec_fn_return`

## Requirements
- R1: With `sec_present`=1, a target of 0xFF000000 or above is an exception return, 0xFEFFFFFE and 0xFEFFFFFF are function returns, and anything lower is an ordinary branch. With `sec_present`=0, only 0xFF000000 and above is magic; every other target is an ordinary branch.
- R2: An ordinary branch pulses `br_plain`. An exception return in handler mode (`in_handler`=1) pulses `exc_ret_req`. An exception return in thread mode produces no pulse of any kind and no memory read.
- R3: The stack slot index is {~`in_handler`, `sp_alt_sel`}. Slot k is `sp_bank`[32k+31:32k]. The same index is reported on `sp_wr_idx` when the stack pointer is written back.
- R4: A function return reads address F (the selected slot's value) first and then F+4. `mem_secure` is high during both reads, and each request with its address is held until `mem_ack`.
- R5: The return is consistent when `cur_exc`=0 and the saved field (status bits [EXC_W-1:0]) is 0, or when `cur_exc`=1 and the saved field is nonzero. Any other combination pulses `usage_fault` with no commit.
- R6: On a consistent return, `ret_done` pulses with `sp_wr_en` high and `sp_wr_data`=F+8. The same pulse sets `new_exc` to the saved field and `new_fpa` to status bit FPA_BIT (default 20). `ret_done` also means: switch to secure state and clear the conditional-block state.
- R7: On `ret_done`, `new_mode` equals bit 0 of the loaded return word and `new_pc` is that word with bit 0 cleared.
- R8: `mem_err` on either read pulses `mem_fault`, ends the sequence with no `ret_done`, no `usage_fault` and no stack write, and issues no further read.
- R9: `br_valid` is ignored while a function-return sequence is in progress.
- R10: After reset every pulse output and `mem_req` are low. Counting the cycle after the accepting edge as cycle 1, and with a memory that acknowledges at once: `br_plain`/`exc_ret_req` appear in cycle 1, the reads fall in cycles 1 and 2, the outcome appears in cycle 3, and a first-read error appears in cycle 2. At most one outcome pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch target offered |
| br_target | input | 32 | Branch target value |
| sec_present | input | 1 | Security extension configured |
| in_handler | input | 1 | Core is in handler mode |
| sp_alt_sel | input | 1 | Alternate stack select bit |
| cur_exc | input | EXC_W | Current exception number |
| sp_bank | input | 128 | Four secure stack pointers, slot k at [32k+31:32k] |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_secure | output | 1 | Read is a secure access |
| mem_ack | input | 1 | Read completes this cycle |
| mem_err | input | 1 | Completing read had a bus error |
| mem_rdata | input | 32 | Read data |
| br_plain | output | 1 | Ordinary branch pulse |
| exc_ret_req | output | 1 | Exception-return request pulse |
| ret_done | output | 1 | Function return committed |
| usage_fault | output | 1 | Inconsistent return, invalid-PC usage fault |
| mem_fault | output | 1 | Bus error during unstack |
| new_pc | output | 32 | Restored PC, bit 0 clear |
| new_mode | output | 1 | Restored instruction-mode bit |
| new_exc | output | EXC_W | Restored exception number |
| new_fpa | output | 1 | Restored floating-point-secure-active bit |
| sp_wr_en | output | 1 | Stack pointer write-back |
| sp_wr_idx | output | 2 | Slot being written |
| sp_wr_data | output | 32 | New stack pointer value |

## Verification
Classification pulses are due one cycle after the accepting edge. Read addresses are due in the first and second cycles. A commit or usage fault is due in the third cycle, and a bus error in the second or third cycle depending on which read fails. After each launch, the bench samples every port on the falling edge of each of the next five cycles. It records the cycle in which each pulse first shows and how many times it shows, and compares both with the cycle numbers stated in R10. This also catches a pulse that arrives late, arrives twice, or appears where none is due.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned NUM_SP = 4;
  localparam int unsigned SP_IW  = $clog2(NUM_SP);

  typedef enum logic [1:0] {
    BR_PLAIN  = 2'd0,
    BR_EXCRET = 2'd1,
    BR_FNRET  = 2'd2
  } br_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LD_PC  = 2'd1,
    ST_LD_PSR = 2'd2
  } seq_st_e;

  // Sort a branch target against the two magic floors.
  function automatic br_kind_e classify(input logic [31:0] tgt,
                                        input logic        sec,
                                        input logic [31:0] exc_floor,
                                        input logic [31:0] fn_floor);
    if (tgt >= exc_floor)             return BR_EXCRET;
    else if (sec && tgt >= fn_floor)  return BR_FNRET;
    else                              return BR_PLAIN;
  endfunction

  // Stack slot picked by mode and alternate select.
  function automatic logic [SP_IW-1:0] bank_index(input logic handler,
                                                  input logic alt);
    return {~handler, alt};
  endfunction

  // Status consistency between current and saved exception numbers.
  function automatic logic frame_ok(input logic cur_zero,
                                    input logic cur_one,
                                    input logic saved_nz);
    return (cur_zero && !saved_nz) || (cur_one && saved_nz);
  endfunction

  function automatic logic [31:0] step_frame(input logic [31:0] f);
    return f + 32'd8;
  endfunction

  function automatic logic [31:0] second_word(input logic [31:0] f);
    return f + 32'd4;
  endfunction

endpackage

// File: rtl/sfr_classify.sv
module sfr_classify
  import sfr_pkg::*;
#(
  parameter logic [31:0] EXC_FLOOR = 32'hFF00_0000,
  parameter logic [31:0] FN_FLOOR  = 32'hFEFF_FFFE
) (
  input  logic [31:0] target,
  input  logic        sec_present,
  output br_kind_e    kind
);
  assign kind = classify(target, sec_present, EXC_FLOOR, FN_FLOOR);
endmodule

// File: rtl/sfr_bank_mux.sv
module sfr_bank_mux #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N*W-1:0] flat,
  input  logic [IW-1:0]  sel,
  output logic [W-1:0]   word
);
  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = flat[g*W +: W];
  end

  assign word = slot[sel];
endmodule

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] frame_in,
  output logic        idle,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic [31:0] frame_q,
  output logic [31:0] pc_word,
  output logic [31:0] psr_word,
  output logic        fetch_done,
  output logic        fetch_err
);
  seq_st_e st_q;

  assign idle     = (st_q == ST_IDLE);
  assign mem_req  = (st_q == ST_LD_PC) || (st_q == ST_LD_PSR);
  assign mem_addr = (st_q == ST_LD_PSR) ? second_word(frame_q) : frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      frame_q    <= '0;
      pc_word    <= '0;
      psr_word   <= '0;
      fetch_done <= 1'b0;
      fetch_err  <= 1'b0;
    end else begin
      fetch_done <= 1'b0;
      fetch_err  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            frame_q <= frame_in;
            st_q    <= ST_LD_PC;
          end
        end
        ST_LD_PC: begin
          if (mem_ack) begin
            if (mem_err) begin
              fetch_err <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              pc_word <= mem_rdata;
              st_q    <= ST_LD_PSR;
            end
          end
        end
        ST_LD_PSR: begin
          if (mem_ack) begin
            if (mem_err) fetch_err <= 1'b1;
            else begin
              psr_word   <= mem_rdata;
              fetch_done <= 1'b1;
            end
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

  AST_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LD_PC && mem_ack && !mem_err) |=>
      (mem_req && mem_addr == $past(mem_addr) + 32'd4)); // R4

endmodule

// File: rtl/sfr_commit.sv
module sfr_commit
  import sfr_pkg::*;
#(
  parameter int unsigned EXC_W   = 9,
  parameter int unsigned FPA_BIT = 20
) (
  input  logic             fetch_done,
  input  logic [31:0]      pc_word,
  input  logic [31:0]      psr_word,
  input  logic [EXC_W-1:0] cur_exc,
  input  logic [31:0]      frame,
  output logic             ret_done,
  output logic             usage_fault,
  output logic [31:0]      new_pc,
  output logic             new_mode,
  output logic [EXC_W-1:0] new_exc,
  output logic             new_fpa,
  output logic             sp_wr_en,
  output logic [31:0]      sp_wr_data
);
  logic [EXC_W-1:0] saved_exc;
  logic             consistent;

  assign saved_exc  = psr_word[EXC_W-1:0];
  assign consistent = frame_ok(cur_exc == '0,
                               cur_exc == EXC_W'(1),
                               |saved_exc);

  assign ret_done    = fetch_done && consistent;
  assign usage_fault = fetch_done && !consistent;
  assign sp_wr_en    = ret_done;
  assign sp_wr_data  = step_frame(frame);
  assign new_pc      = {pc_word[31:1], 1'b0};
  assign new_mode    = pc_word[0];
  assign new_exc     = saved_exc;
  assign new_fpa     = psr_word[FPA_BIT];
endmodule

// File: rtl/sec_fn_return.sv
module sec_fn_return
  import sfr_pkg::*;
#(
  parameter logic [31:0] EXC_FLOOR = 32'hFF00_0000,
  parameter logic [31:0] FN_FLOOR  = 32'hFEFF_FFFE,
  parameter int unsigned EXC_W     = 9,
  parameter int unsigned FPA_BIT   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_valid,
  input  logic [31:0]         br_target,
  input  logic                sec_present,
  input  logic                in_handler,
  input  logic                sp_alt_sel,
  input  logic [EXC_W-1:0]    cur_exc,
  input  logic [NUM_SP*32-1:0] sp_bank,
  output logic                mem_req,
  output logic [31:0]         mem_addr,
  output logic                mem_secure,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [31:0]         mem_rdata,
  output logic                br_plain,
  output logic                exc_ret_req,
  output logic                ret_done,
  output logic                usage_fault,
  output logic                mem_fault,
  output logic [31:0]         new_pc,
  output logic                new_mode,
  output logic [EXC_W-1:0]    new_exc,
  output logic                new_fpa,
  output logic                sp_wr_en,
  output logic [SP_IW-1:0]    sp_wr_idx,
  output logic [31:0]         sp_wr_data
);
  br_kind_e         kind;
  logic             seq_idle;
  logic             accept;
  logic             start_fn;
  logic [SP_IW-1:0] idx_now;
  logic [31:0]      frame_now;
  logic [31:0]      frame_q;
  logic [31:0]      pc_word;
  logic [31:0]      psr_word;
  logic             fetch_done;
  logic             fetch_err;
  logic [EXC_W-1:0] cur_exc_q;
  logic [SP_IW-1:0] idx_q;
  logic             plain_q;
  logic             excret_q;

  sfr_classify #(.EXC_FLOOR(EXC_FLOOR), .FN_FLOOR(FN_FLOOR)) u_cls (
    .target      (br_target),
    .sec_present (sec_present),
    .kind        (kind)
  );

  assign accept   = br_valid && seq_idle;
  assign start_fn = accept && (kind == BR_FNRET);
  assign idx_now  = bank_index(in_handler, sp_alt_sel);

  sfr_bank_mux #(.W(32), .N(NUM_SP)) u_bank (
    .flat (sp_bank),
    .sel  (idx_now),
    .word (frame_now)
  );

  sfr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_fn),
    .frame_in   (frame_now),
    .idle       (seq_idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_rdata  (mem_rdata),
    .frame_q    (frame_q),
    .pc_word    (pc_word),
    .psr_word   (psr_word),
    .fetch_done (fetch_done),
    .fetch_err  (fetch_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_exc_q <= '0;
      idx_q     <= '0;
      plain_q   <= 1'b0;
      excret_q  <= 1'b0;
    end else begin
      plain_q  <= accept && (kind == BR_PLAIN);
      excret_q <= accept && (kind == BR_EXCRET) && in_handler;
      if (start_fn) begin
        cur_exc_q <= cur_exc;
        idx_q     <= idx_now;
      end
    end
  end

  sfr_commit #(.EXC_W(EXC_W), .FPA_BIT(FPA_BIT)) u_commit (
    .fetch_done  (fetch_done),
    .pc_word     (pc_word),
    .psr_word    (psr_word),
    .cur_exc     (cur_exc_q),
    .frame       (frame_q),
    .ret_done    (ret_done),
    .usage_fault (usage_fault),
    .new_pc      (new_pc),
    .new_mode    (new_mode),
    .new_exc     (new_exc),
    .new_fpa     (new_fpa),
    .sp_wr_en    (sp_wr_en),
    .sp_wr_data  (sp_wr_data)
  );

  assign mem_secure  = mem_req;
  assign mem_fault   = fetch_err;
  assign br_plain    = plain_q;
  assign exc_ret_req = excret_q;
  assign sp_wr_idx   = idx_q;

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_done, usage_fault, mem_fault, exc_ret_req, br_plain})); // R10

  AST_THREAD_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == BR_EXCRET && !in_handler) |=>
      (!exc_ret_req && !br_plain && !mem_req)); // R2

  AST_SP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |-> (sp_wr_data == $past(mem_addr) + 32'd4)); // R6

  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |-> (!mem_req && !sp_wr_en && !usage_fault)); // R8

endmodule

// File: tb/sec_fn_return_test.sv
`timescale 1ns/1ps
module sec_fn_return_test;
  localparam int EXC_W = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic              br_valid;
  logic [31:0]       br_target;
  logic              sec_present, in_handler, sp_alt_sel;
  logic [EXC_W-1:0]  cur_exc;
  logic [127:0]      sp_bank;
  logic              mem_req, mem_secure, mem_ack, mem_err;
  logic [31:0]       mem_addr, mem_rdata;
  logic              br_plain, exc_ret_req, ret_done, usage_fault, mem_fault;
  logic [31:0]       new_pc, sp_wr_data;
  logic              new_mode, new_fpa, sp_wr_en;
  logic [EXC_W-1:0]  new_exc;
  logic [1:0]        sp_wr_idx;

  sec_fn_return uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .sec_present(sec_present), .in_handler(in_handler), .sp_alt_sel(sp_alt_sel),
    .cur_exc(cur_exc), .sp_bank(sp_bank),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_secure(mem_secure),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .br_plain(br_plain), .exc_ret_req(exc_ret_req), .ret_done(ret_done),
    .usage_fault(usage_fault), .mem_fault(mem_fault),
    .new_pc(new_pc), .new_mode(new_mode), .new_exc(new_exc), .new_fpa(new_fpa),
    .sp_wr_en(sp_wr_en), .sp_wr_idx(sp_wr_idx), .sp_wr_data(sp_wr_data)
  );

  // Memory model: zero wait, words placed at the expected frame
  logic [31:0] exp_frame, pc_w, psr_w;
  logic        err0, err1;
  assign mem_ack = mem_req;
  always_comb begin
    if (mem_addr == exp_frame)              mem_rdata = pc_w;
    else if (mem_addr == exp_frame + 32'd4) mem_rdata = psr_w;
    else                                    mem_rdata = 32'hBAD0_BAD0;
    mem_err = mem_req && ((mem_addr == exp_frame && err0) ||
                          (mem_addr == exp_frame + 32'd4 && err1));
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_val(input int k);
    return 32'h2000_1000 + 32'(k) * 32'h100;
  endfunction

  // Observation record
  int n_plain, n_exc, n_done, n_uf, n_mf;
  int k_plain, k_exc, k_done, k_uf, k_mf;
  logic [31:0] a1, a2, o_pc, o_sp;
  logic r1, r2, s1, o_mode, o_fpa;
  logic [EXC_W-1:0] o_exc;
  logic [1:0] o_idx;

  task automatic observe(input bit poke);
    n_plain = 0; n_exc = 0; n_done = 0; n_uf = 0; n_mf = 0;
    k_plain = 0; k_exc = 0; k_done = 0; k_uf = 0; k_mf = 0;
    for (int k = 1; k <= 5; k++) begin
      if (k == 1) begin a1 = mem_addr; r1 = mem_req; s1 = mem_secure; end
      if (k == 2) begin a2 = mem_addr; r2 = mem_req; end
      if (br_plain)    begin n_plain++; if (k_plain == 0) k_plain = k; end
      if (exc_ret_req) begin n_exc++;   if (k_exc == 0)   k_exc = k;   end
      if (usage_fault) begin n_uf++;    if (k_uf == 0)    k_uf = k;    end
      if (mem_fault)   begin n_mf++;    if (k_mf == 0)    k_mf = k;    end
      if (ret_done) begin
        n_done++;
        if (k_done == 0) k_done = k;
        o_pc = new_pc; o_mode = new_mode; o_exc = new_exc; o_fpa = new_fpa;
        o_sp = sp_wr_en ? sp_wr_data : 32'hFFFF_FFFF; o_idx = sp_wr_idx;
      end
      if (k == 1 && poke) begin br_valid = 1'b1; br_target = 32'h0000_0100; end
      @(negedge clk);
      br_valid = 1'b0;
    end
  endtask

  task automatic launch(input logic [31:0] t, input bit sec, input bit hnd,
                        input bit alt, input logic [EXC_W-1:0] cx, input bit poke);
    @(negedge clk);
    br_target = t; sec_present = sec; in_handler = hnd; sp_alt_sel = alt;
    cur_exc = cx; br_valid = 1'b1;
    exp_frame = slot_val((hnd ? 0 : 2) + (alt ? 1 : 0));
    @(negedge clk);
    br_valid = 1'b0;
    observe(poke);
  endtask

  logic [31:0] targets [7];

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; br_target = '0; sec_present = 1'b0;
    in_handler = 1'b0; sp_alt_sel = 1'b0; cur_exc = '0;
    err0 = 1'b0; err1 = 1'b0; pc_w = 32'h0000_4001; psr_w = '0; exp_frame = '0;
    for (int k = 0; k < 4; k++) sp_bank[k*32 +: 32] = slot_val(k);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!mem_req && !br_plain && !exc_ret_req && !ret_done && !usage_fault && !mem_fault,
        "R10 reset", {27'd0, mem_req, br_plain, exc_ret_req, ret_done, usage_fault}, 32'd0);
    rst_n = 1'b1;

    // R1/R2/R10 classification sweep
    targets[0] = 32'h0000_0000; targets[1] = 32'h1000_0001; targets[2] = 32'hFEFF_FFFD;
    targets[3] = 32'hFEFF_FFFE; targets[4] = 32'hFEFF_FFFF; targets[5] = 32'hFF00_0000;
    targets[6] = 32'hFFFF_FFFF;
    for (int ti = 0; ti < 7; ti++)
      for (int sc = 0; sc < 2; sc++)
        for (int hd = 0; hd < 2; hd++) begin
          bit is_exc, is_fn, is_pl;
          pc_w = 32'h0000_4001; psr_w = 32'h0; err0 = 0; err1 = 0;
          launch(targets[ti], sc[0], hd[0], 1'b0, '0, 1'b0);
          is_exc = targets[ti] >= 32'hFF00_0000;
          is_fn  = !is_exc && sc != 0 && targets[ti] >= 32'hFEFF_FFFE;
          is_pl  = !is_exc && !is_fn;
          chk(n_plain == (is_pl ? 1 : 0) && (!is_pl || k_plain == 1), "R1 plain pulse",
              32'(n_plain), 32'(is_pl));
          chk(n_exc == ((is_exc && hd != 0) ? 1 : 0) && (n_exc == 0 || k_exc == 1),
              "R2 exc-ret pulse", 32'(n_exc), 32'(is_exc && hd != 0));
          chk(r1 == is_fn, "R1 read started", 32'(r1), 32'(is_fn));
          chk(n_done == (is_fn ? 1 : 0) && (!is_fn || k_done == 3), "R10 outcome cycle",
              32'(k_done), is_fn ? 32'd3 : 32'd0);
          if (is_exc && hd == 0)
            chk(n_plain + n_exc + n_done + n_uf + n_mf == 0 && !r1 && !r2,
                "R2 thread exc quiet", 32'(n_plain + n_exc + n_done), 32'd0);
        end

    // R3..R7 unstack sweep
    for (int hd = 0; hd < 2; hd++)
      for (int al = 0; al < 2; al++)
        for (int cx = 0; cx < 3; cx++)
          for (int sv = 0; sv < 4; sv++)
            for (int md = 0; md < 2; md++)
              for (int fp = 0; fp < 2; fp++) begin
                logic [EXC_W-1:0] saved;
                logic [31:0] fr;
                bit ok;
                int idx;
                saved = (sv == 0) ? 9'd0 : (sv == 1) ? 9'd1 : (sv == 2) ? 9'd5 : 9'd511;
                pc_w  = 32'h0800_0000 + 32'(cx * 64 + sv * 16) + 32'(md);
                psr_w = 32'h0100_0000 | (32'(fp) << 20) | 32'(saved);
                err0 = 0; err1 = 0;
                launch(32'hFEFF_FFFF, 1'b1, hd[0], al[0], EXC_W'(cx), 1'b0);
                idx = (hd != 0 ? 0 : 2) + al;
                fr  = slot_val(idx);
                ok  = (cx == 0 && saved == 0) || (cx == 1 && saved != 0);
                chk(r1 && a1 == fr, "R3 first read at slot", a1, fr);
                chk(s1, "R4 secure access", 32'(s1), 32'd1);
                chk(r2 && a2 == fr + 32'd4, "R4 second read", a2, fr + 32'd4);
                chk(n_done == (ok ? 1 : 0) && n_uf == (ok ? 0 : 1), "R5 consistency",
                    32'(n_done), 32'(ok));
                chk(ok ? k_done == 3 : k_uf == 3, "R10 outcome cycle",
                    32'(ok ? k_done : k_uf), 32'd3);
                if (ok) begin
                  chk(o_sp == fr + 32'd8, "R6 stack advance", o_sp, fr + 32'd8);
                  chk(o_idx == 2'(idx), "R3 write slot", 32'(o_idx), 32'(idx));
                  chk(o_exc == saved, "R6 exception number", 32'(o_exc), 32'(saved));
                  chk(o_fpa == fp[0], "R6 fp-active bit", 32'(o_fpa), 32'(fp));
                  chk(o_pc == (pc_w & ~32'd1), "R7 new pc", o_pc, pc_w & ~32'd1);
                  chk(o_mode == md[0], "R7 mode bit", 32'(o_mode), 32'(md));
                end
              end

    // R8 bus errors
    for (int e = 0; e < 2; e++)
      for (int hd = 0; hd < 2; hd++) begin
        pc_w = 32'h0000_2001; psr_w = 32'h0; err0 = (e == 0); err1 = (e == 1);
        launch(32'hFEFF_FFFE, 1'b1, hd[0], 1'b1, '0, 1'b0);
        chk(n_mf == 1 && k_mf == (e == 0 ? 2 : 3), "R8 fault cycle",
            32'(k_mf), e == 0 ? 32'd2 : 32'd3);
        chk(n_done == 0 && n_uf == 0, "R8 no commit", 32'(n_done + n_uf), 32'd0);
        if (e == 0) chk(!r2, "R8 no second read", 32'(r2), 32'd0);
      end
    err0 = 0; err1 = 0;

    // R9 branch offered while busy
    pc_w = 32'h0000_3001; psr_w = 32'h0;
    launch(32'hFEFF_FFFE, 1'b1, 1'b0, 1'b0, '0, 1'b1);
    chk(n_plain == 0, "R9 busy ignore", 32'(n_plain), 32'd0);
    chk(n_done == 1 && k_done == 3, "R9 sequence intact", 32'(k_done), 32'd3);
    // follow-up: accepted once idle
    launch(32'h0000_0100, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    chk(n_plain == 1 && k_plain == 1, "R9 accepted when idle", 32'(n_plain), 32'd1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule